// File: doc/BRIEF.md
# PWM Channel Status and Interrupt Flag Register

This block is the 8-bit flag register of one channel in a multi-channel PWM stage. Five kinds of hardware event set flags in it. A level change on either of the channel's two PWM outputs sets an activity flag. In auto-run mode, the channel's end-of-cycle can fall out of step with that of the upstream channel that drives its run input, and this sets a synchronisation-error flag. An external capture or retrigger strobe from either of two event blocks sets an event flag. The channel's own end-of-cycle strobe sets an end-of-cycle flag. Each time an event flag is set, the register also stores the 2-bit ramp number that is current at that moment.

Software reads the register and clears flags by writing ones to them. An interrupt request is raised while any flag is set and its enable input is high. The waveform generator, the event filtering and the bus decode are outside this block. It sees them only as strobes and levels. The parameters give the channel count and this channel's index, and the upstream channel is derived from them.

Top module: `pwm_flag_reg`

## Requirements
- R1: After reset, `flagsOut` is 8'h00 and `irqReq` is 0.
- R2: Bit 7 of `flagsOut` is 1 in the cycle after any clock edge at which `outB` differs from its value at the previous edge. Rising and falling changes both count.
- R3: Bit 6 of `flagsOut` behaves the same way for `outA`.
- R4: Bit 5 sets when `autoRun` is 1 and exactly one of these two strobes is high in a clock: this channel's end-of-cycle strobe, or the upstream channel's end-of-cycle strobe. It does not set when `autoRun` is 0, and it does not set when both strobes are high in the same clock.
- R5: This channel's strobe is `chanEoc[CHAN_IDX]`. The upstream strobe is `chanEoc[CHAN_IDX-1]`, except for channel 0, which takes `chanEoc[NUM_CHAN-1]`. Strobes of other channels have no effect.
- R6: Bit 4 sets on `evtB` and bit 3 sets on `evtA`. These flags set and read back even when their `irqEn` bits are 0.
- R7: Bits 2:1 load `rampNum` in any cycle in which `evtA` or `evtB` is high. In every other cycle they hold their value, and writes do not change them.
- R8: A write (`wrEn`=1) clears each flag in bits 7..3 and bit 0 whose `wrData` bit is 1. A 0 in `wrData` leaves the flag unchanged.
- R9: If a flag is set by hardware and cleared by a write in the same cycle, the flag ends up set.
- R10: Bit 0 sets on this channel's end-of-cycle strobe, whatever the value of `autoRun`.
- R11: `irqReq` is the OR of (`flagsOut[i]` AND `irqEn[i]`) for i in 7..3 and 0. It follows the flags combinationally, and bits 2:1 of `irqEn` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| outA | input | 1 | PWM output A level |
| outB | input | 1 | PWM output B level |
| autoRun | input | 1 | Channel is in auto-run mode |
| chanEoc | input | NUM_CHAN | End-of-cycle strobes of all channels |
| evtA | input | 1 | Event strobe from event block A |
| evtB | input | 1 | Event strobe from event block B |
| rampNum | input | 2 | Current ramp number |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data; a 1 clears the matching flag |
| irqEn | input | 8 | Interrupt enables per flag bit |
| flagsOut | output | 8 | Register read value |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench covers the collision of a toggle and a write clear on the same bit. A design that let the clear win would lose that edge. It drives both end-of-cycle strobes together in auto-run, and strobes a channel that is not upstream. A wrong upstream index or a plain OR of the strobes would raise a false synchronisation error. It changes the ramp number between events and writes all ones with no event present, which exposes a ramp field that latches every cycle or is cleared by writes. Finally, it moves the enables onto the ramp bits only, which catches an interrupt that uses the two read-only positions.

// File: rtl/pwm_flag_pkg.sv
package pwm_flag_pkg;
  localparam int FLAG_W = 8;
  localparam int RAMP_W = 2;
  localparam int RAMP_LSB = 1;
  localparam logic [FLAG_W-1:0] W1C_MASK = 8'hF9;

  typedef struct packed {
    logic actB;
    logic actA;
    logic syncErr;
    logic evB;
    logic evA;
    logic eoc;
  } flag_set_t;
endpackage

// File: rtl/pwm_flag_ctrl.sv
module pwm_flag_ctrl
  import pwm_flag_pkg::*;
#(
  parameter int NUM_CHAN = 3,
  parameter int CHAN_IDX = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                outA,
  input  logic                outB,
  input  logic                autoRun,
  input  logic [NUM_CHAN-1:0] chanEoc,
  input  logic                evtA,
  input  logic                evtB,
  output flag_set_t           setStb
);
  localparam int UP_IDX = (CHAN_IDX == 0) ? NUM_CHAN - 1 : CHAN_IDX - 1;

  logic prevA, prevB;
  logic ownEoc, upEoc;

  assign ownEoc = chanEoc[CHAN_IDX];
  assign upEoc  = chanEoc[UP_IDX];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= outA;
      prevB <= outB;
    end
  end

  always_comb begin
    setStb.actB    = outB ^ prevB;
    setStb.actA    = outA ^ prevA;
    setStb.syncErr = autoRun & (ownEoc ^ upEoc);
    setStb.evB     = evtB;
    setStb.evA     = evtA;
    setStb.eoc     = ownEoc;
  end

  // R4: no sync error outside auto-run
  p_idle_sync_r4: assert property (@(posedge clk) disable iff (!rstN)
    !autoRun |-> !setStb.syncErr);
  // R5: coincident own and upstream strobes are in step
  p_coincide_r5: assert property (@(posedge clk) disable iff (!rstN)
    (chanEoc[CHAN_IDX] && chanEoc[UP_IDX]) |-> !setStb.syncErr);
endmodule

// File: rtl/pwm_flag_dp.sv
module pwm_flag_dp
  import pwm_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flag_set_t         setStb,
  input  logic [RAMP_W-1:0] rampNum,
  input  logic              wrEn,
  input  logic [FLAG_W-1:0] wrData,
  input  logic [FLAG_W-1:0] irqEn,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              irqReq
);
  logic [FLAG_W-1:0] flagReg, setVec, clrVec;
  logic [RAMP_W-1:0] rampReg;
  logic              anyEvt;

  assign setVec = {setStb.actB, setStb.actA, setStb.syncErr, setStb.evB,
                   setStb.evA, {RAMP_W{1'b0}}, setStb.eoc};
  assign clrVec = wrEn ? (wrData & W1C_MASK) : '0;
  assign anyEvt = setStb.evA | setStb.evB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg <= '0;
      rampReg <= '0;
    end else begin
      flagReg <= ((flagReg & ~clrVec) | setVec) & W1C_MASK;
      if (anyEvt) rampReg <= rampNum;
    end
  end

  always_comb begin
    flagsOut = flagReg & W1C_MASK;
    flagsOut[RAMP_LSB +: RAMP_W] = rampReg;
  end

  assign irqReq = |(flagsOut & irqEn & W1C_MASK);

  // R9: a hardware set always lands
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((flagsOut & $past(setVec)) == $past(setVec)));
  // R8: written ones clear unless set the same cycle
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((flagsOut & $past(wrData & W1C_MASK & ~setVec)) == '0));
  // R8: a flag only rises from a hardware set
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagsOut & ~$past(flagsOut) & W1C_MASK & ~$past(setVec)) == '0));
  // R7: ramp field holds without an event
  p_ramp_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !anyEvt |=> $stable(flagsOut[RAMP_LSB +: RAMP_W]));
endmodule

// File: rtl/pwm_flag_reg.sv
module pwm_flag_reg
  import pwm_flag_pkg::*;
#(
  parameter int NUM_CHAN = 3,
  parameter int CHAN_IDX = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                outA,
  input  logic                outB,
  input  logic                autoRun,
  input  logic [NUM_CHAN-1:0] chanEoc,
  input  logic                evtA,
  input  logic                evtB,
  input  logic [1:0]          rampNum,
  input  logic                wrEn,
  input  logic [7:0]          wrData,
  input  logic [7:0]          irqEn,
  output logic [7:0]          flagsOut,
  output logic                irqReq
);
  flag_set_t setStb;

  pwm_flag_ctrl #(.NUM_CHAN(NUM_CHAN), .CHAN_IDX(CHAN_IDX)) uCtrl (
    .clk(clk), .rstN(rstN), .outA(outA), .outB(outB), .autoRun(autoRun),
    .chanEoc(chanEoc), .evtA(evtA), .evtB(evtB), .setStb(setStb)
  );

  pwm_flag_dp uDp (
    .clk(clk), .rstN(rstN), .setStb(setStb), .rampNum(rampNum),
    .wrEn(wrEn), .wrData(wrData), .irqEn(irqEn),
    .flagsOut(flagsOut), .irqReq(irqReq)
  );
endmodule

// File: tb/tb_pwm_flag_reg.sv
module tb_pwm_flag_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic outA = 0, outB = 0, autoRun = 0, evtA = 0, evtB = 0, wrEn = 0;
  logic [2:0] chanEoc = '0;
  logic [1:0] rampNum = '0;
  logic [7:0] wrData = '0, irqEn = 8'hFF;
  logic [7:0] flagsOut;
  logic irqReq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_flag_reg #(.NUM_CHAN(3), .CHAN_IDX(0)) dut (
    .clk(clk), .rstN(rstN), .outA(outA), .outB(outB), .autoRun(autoRun),
    .chanEoc(chanEoc), .evtA(evtA), .evtB(evtB), .rampNum(rampNum),
    .wrEn(wrEn), .wrData(wrData), .irqEn(irqEn),
    .flagsOut(flagsOut), .irqReq(irqReq)
  );

  typedef struct packed {
    logic a, b, ar;
    logic [2:0] eoc;
    logic ea, eb;
    logic [1:0] ramp;
    logic we;
    logic [7:0] wd;
    logic [7:0] expF;
    logic expIrq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,3'b000,0,0,2'd0,0,8'h00,8'h40,1},
    '{1,1,0,3'b000,0,0,2'd0,0,8'h00,8'hC0,1},
    '{1,1,0,3'b000,0,0,2'd0,1,8'h40,8'h80,1},
    '{1,0,0,3'b000,0,0,2'd0,1,8'h80,8'h80,1},
    '{1,0,0,3'b000,0,0,2'd0,1,8'h00,8'h80,1},
    '{1,0,0,3'b000,0,0,2'd0,1,8'hFF,8'h00,0},
    '{1,0,0,3'b000,1,0,2'd2,0,8'h00,8'h0C,1},
    '{1,0,0,3'b000,0,1,2'd1,0,8'h00,8'h1A,1},
    '{1,0,0,3'b000,0,0,2'd3,0,8'h00,8'h1A,1},
    '{1,0,0,3'b000,0,0,2'd3,1,8'hFF,8'h02,0},
    '{1,0,0,3'b001,0,0,2'd3,0,8'h00,8'h03,1},
    '{1,0,1,3'b101,0,0,2'd3,0,8'h00,8'h03,1},
    '{1,0,1,3'b100,0,0,2'd3,0,8'h00,8'h23,1},
    '{1,0,1,3'b010,0,0,2'd3,1,8'hFF,8'h02,0},
    '{1,0,1,3'b001,0,0,2'd3,0,8'h00,8'h23,1}
  };
  localparam string TAGS [NV] = '{
    "R3", "R2", "R8", "R9", "R8", "R8", "R6 R7", "R6 R7",
    "R7", "R7 R8", "R10", "R4", "R4", "R5", "R4 R10"
  };

  task automatic check(input string tag, input logic [7:0] actF,
                       input logic [7:0] expF, input logic actI, input logic expI);
    checks++;
    if (actF !== expF || actI !== expI) begin
      fails++;
      $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b",
               tag, actF, actI, expF, expI);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", flagsOut, 8'h00, irqReq, 1'b0);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      outA = VECS[i].a; outB = VECS[i].b; autoRun = VECS[i].ar;
      chanEoc = VECS[i].eoc; evtA = VECS[i].ea; evtB = VECS[i].eb;
      rampNum = VECS[i].ramp; wrEn = VECS[i].we; wrData = VECS[i].wd;
      @(posedge clk);
      #1 check(TAGS[i], flagsOut, VECS[i].expF, irqReq, VECS[i].expIrq);
    end

    @(negedge clk);
    chanEoc = '0; wrEn = 0; autoRun = 0;
    // R11: enables only on read-only ramp bits give no request
    irqEn = 8'h06;
    #1 check("R11 ramp enables", flagsOut, 8'h23, irqReq, 1'b0);
    // R6: flags still read back with enables off
    irqEn = 8'h00;
    @(negedge clk) evtA = 1; rampNum = 2'd0;
    @(posedge clk);
    #1 check("R6 disabled", flagsOut, 8'h29, irqReq, 1'b0);
    @(negedge clk) evtA = 0; irqEn = 8'h01;
    #1 check("R11 bit0", flagsOut, 8'h29, irqReq, 1'b1);
    irqEn = 8'h08;
    #1 check("R11 bit3", flagsOut, 8'h29, irqReq, 1'b1);
    // R2: falling edge of B after rising
    @(negedge clk) outB = 1;
    @(posedge clk);
    @(negedge clk) wrEn = 1; wrData = 8'h80;
    @(posedge clk);
    @(negedge clk) wrEn = 0; outB = 0;
    @(posedge clk);
    #1 check("R2 fall", flagsOut & 8'h80, 8'h80, irqReq, 1'b1);
    // R1: reset in mid-run clears everything
    @(negedge clk) rstN = 0;
    @(posedge clk);
    #1 check("R1 mid-run", flagsOut, 8'h00, irqReq, 1'b0);
    finishRun();
  end
endmodule